// File: doc/BRIEF.md
# Banked Data Address Mapper

This block sits between a small CPU's 8-bit data address bus and its storage. The top half of the address space (0x80-0xFF) always reaches fixed destinations. Addresses 0x80-0xEF are peripheral and control registers, which live outside the block and are only selected here. Addresses 0xF0-0xFF are sixteen 8-bit working registers held inside the block. The bottom half (0x00-0x7F) reaches a RAM bank. When the banking strap is on, the bank number is taken from the working register at 0xFF.

The bank-select register at 0xFF steers only ordinary data accesses. A stack access, or any access while banking is off, goes to bank 0. Bank 0 implements only its first `BANK0_SIZE` bytes. Every other implemented bank has all 128 bytes. Reads of a hole return 0xFF, and writes into a hole are dropped. Reads are synchronous. The CPU copies data between banks through the working registers, which are visible whatever bank is selected.

Top module: `bank_addr_map`

## Requirements
- R1: The select outputs decode only in a cycle where `rd_en` or `wr_en` is high. `ctrl_sel` is high for addresses 0x80-0xEF. `reg_sel` is one-hot with bit `addr[3:0]` set for addresses 0xF0-0xFF. Both selects are zero for 0x00-0x7F.
- R2: A read places its data on `rdata` one clock after the cycle in which `rd_en` is high. `rdata` then holds its value until the next read.
- R3: With `bank_en`=1 and `stk_acc`=0, an address in 0x00-0x7F reaches offset `addr[6:0]` of the bank whose number is the value of the working register at 0xFF. A write to 0xFF takes effect from the next access.
- R4: Accesses to 0x80-0xFF are unaffected by the value held at 0xFF. A working register written while one bank is selected reads back the same value while another bank is selected.
- R5: With `bank_en`=0, the value at 0xFF has no effect on decoding, and every lower-half access uses bank 0.
- R6: A lower-half access with `stk_acc`=1 uses bank 0 whatever is held at 0xFF.
- R7: Banks 1 to `NUM_BANKS`-1 each store and return all 128 offsets 0x00-0x7F.
- R8: A read returns 0xFF in two cases: a bank-0 offset at or above `BANK0_SIZE`, or any lower-half address when the bank number is `NUM_BANKS` or larger.
- R9: A write to an unimplemented lower-half location changes no stored byte in any bank.
- R10: A read of 0x80-0xEF returns 0x00 on `rdata`, so that external peripheral data can be merged with it.
- R11: After reset all working registers are 0, so bank 0 is selected, and `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Data address |
| rd_en | input | 1 | Read strobe, never high together with `wr_en` |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| stk_acc | input | 1 | Marks the access as a stack access (forced to bank 0) |
| bank_en | input | 1 | Banking strap: 1 lets 0xFF select the lower-half bank |
| rdata | output | 8 | Read data, one cycle after the read strobe |
| reg_sel | output | 16 | One-hot working-register select for 0xF0-0xFF |
| ctrl_sel | output | 1 | Control-register region select for 0x80-0xEF |

## Verification
The assertions check the following properties on every cycle: the select outputs are exclusive and one-hot, each select decodes only inside its own address range, `rdata` holds between reads, the fill value appears for bank-0 holes, control-region reads return zero, and the output state is correct out of reset. Some behaviours depend on stored contents, and only the bench scenarios can show them. These are the routing to the right bank, the forcing of stack and unbanked accesses to bank 0, the fact that each upper bank is full, the fact that working registers are the same in every bank, and the fact that writes into holes leave every bank unchanged.

// File: rtl/dmap_pkg.sv
// Shared types for the banked data address mapper.
package dmap_pkg;
    localparam int          DATA_W    = 8;
    localparam int          HALF_SIZE = 128;
    localparam int          NUM_WREG  = 16;
    localparam logic [7:0]  HOLE_FILL = 8'hFF;
    localparam logic [7:0]  CTRL_FILL = 8'h00;

    typedef enum logic [1:0] {RGN_RAM, RGN_CTRL, RGN_WREG} region_e;
    typedef enum logic [1:0] {SRC_CTRL, SRC_RAM, SRC_HOLE, SRC_WREG} src_e;
endpackage

// File: rtl/dmap_decode.sv
// Address decoder: classifies an address into region, applies bank choice and
// produces the flat physical index plus an "implemented" flag for the RAM half.
// Assumes bank 0 is packed first, then banks 1..NUM_BANKS-1 at 128 bytes each.
module dmap_decode
    import dmap_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK0_SIZE = 112,
    parameter int PHYS_W     = 9
) (
    input  logic [7:0]        addr,
    input  logic              stk_acc,
    input  logic              bank_en,
    input  logic [7:0]        bank_val,
    output region_e           region,
    output logic              impl,
    output logic [PHYS_W-1:0] phys
);
    logic [7:0] eff_bank;
    logic [6:0] off;
    int         phys_int;

    assign off = addr[6:0];

    // Region classification from the top address bits.
    always_comb begin
        if (!addr[7])                region = RGN_RAM;
        else if (addr[7:4] == 4'hF)  region = RGN_WREG;
        else                         region = RGN_CTRL;
    end

    // Bank choice: stack and unbanked accesses use bank 0.
    assign eff_bank = (bank_en && !stk_acc) ? bank_val : 8'd0;

    // Implemented check and flat index computation.
    always_comb begin
        if (eff_bank == 8'd0) begin
            impl     = (region == RGN_RAM) && (int'(off) < BANK0_SIZE);
            phys_int = int'(off);
        end else begin
            impl     = (region == RGN_RAM) && (int'(eff_bank) < NUM_BANKS);
            phys_int = BANK0_SIZE + (int'(eff_bank) - 1) * HALF_SIZE + int'(off);
        end
        phys = phys_int[PHYS_W-1:0];
    end
endmodule

// File: rtl/dmap_regfile.sv
// Sixteen working registers. Index 15 also drives the bank-select value.
// Assumes read and write strobes are never high in the same cycle.
module dmap_regfile
    import dmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       re,
    input  logic [3:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rd_q,
    output logic [7:0] bank_val
);
    logic [7:0] regs [NUM_WREG];

    for (genvar g = 0; g < NUM_WREG; g++) begin : g_wreg
        // Per-register storage with its own write enable.
        always_ff @(posedge clk) begin
            if (!rst_n)                        regs[g] <= '0;
            else if (we && idx == 4'(g))       regs[g] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_q <= '0;
        else if (re)  rd_q <= regs[idx];
    end

    assign bank_val = regs[NUM_WREG-1];
endmodule

// File: rtl/dmap_ram.sv
// Flat single-port storage for all implemented bank bytes, synchronous read.
// Contents are not reset; only the output register is.
module dmap_ram #(
    parameter int DEPTH  = 496,
    parameter int PHYS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [PHYS_W-1:0] idx,
    input  logic [7:0]        wdata,
    output logic [7:0]        q
);
    logic [7:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Read port register.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (re)  q <= mem[idx];
    end
endmodule

// File: rtl/bank_addr_map.sv
// Top of the banked data address mapper. Decodes each access, routes lower-half
// traffic to the chosen bank, holds the working registers, and returns read
// data one cycle later. Assumes rd_en and wr_en are mutually exclusive.
module bank_addr_map
    import dmap_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int BANK0_SIZE = 112
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  addr,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    input  logic        stk_acc,
    input  logic        bank_en,
    output logic [7:0]  rdata,
    output logic [15:0] reg_sel,
    output logic        ctrl_sel
);
    localparam int DEPTH  = BANK0_SIZE + (NUM_BANKS - 1) * HALF_SIZE;
    localparam int PHYS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    region_e           region;
    logic              impl;
    logic [PHYS_W-1:0] phys;
    logic [7:0]        bank_val;
    logic [7:0]        wreg_q;
    logic [7:0]        ram_q;
    logic              access;
    src_e              src_q;

    assign access = rd_en || wr_en;

    dmap_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK0_SIZE(BANK0_SIZE),
        .PHYS_W    (PHYS_W)
    ) u_decode (
        .addr    (addr),
        .stk_acc (stk_acc),
        .bank_en (bank_en),
        .bank_val(bank_val),
        .region  (region),
        .impl    (impl),
        .phys    (phys)
    );

    dmap_regfile u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en && region == RGN_WREG),
        .re      (rd_en && region == RGN_WREG),
        .idx     (addr[3:0]),
        .wdata   (wdata),
        .rd_q    (wreg_q),
        .bank_val(bank_val)
    );

    dmap_ram #(
        .DEPTH (DEPTH),
        .PHYS_W(PHYS_W)
    ) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_en && impl),
        .re   (rd_en && impl),
        .idx  (phys),
        .wdata(wdata),
        .q    (ram_q)
    );

    // Region selects, active only during an access.
    assign ctrl_sel = access && (region == RGN_CTRL);
    assign reg_sel  = (access && region == RGN_WREG) ? (16'd1 << addr[3:0]) : 16'd0;

    // Remember which source the latest read targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_CTRL;
        end else if (rd_en) begin
            case (region)
                RGN_RAM:  src_q <= impl ? SRC_RAM : SRC_HOLE;
                RGN_WREG: src_q <= SRC_WREG;
                default:  src_q <= SRC_CTRL;
            endcase
        end
    end

    // Output data mux over the registered sources.
    always_comb begin
        case (src_q)
            SRC_RAM:  rdata = ram_q;
            SRC_HOLE: rdata = HOLE_FILL;
            SRC_WREG: rdata = wreg_q;
            default:  rdata = CTRL_FILL;
        endcase
    end
endmodule

// File: rtl/bank_addr_map_chk.sv
// Property checker for bank_addr_map, attached by bind below.
module bank_addr_map_chk #(
    parameter int BANK0_SIZE = 112
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic        stk_acc,
    input logic        bank_en,
    input logic [7:0]  rdata,
    input logic [15:0] reg_sel,
    input logic        ctrl_sel
);
    assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    assert_reg_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_sel) && !(ctrl_sel && reg_sel != 16'd0));

    assert_reg_sel_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel != 16'd0) |-> (addr[7:4] == 4'hF && (rd_en || wr_en) && reg_sel[addr[3:0]]));

    assert_ctrl_sel_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel |-> (addr[7] && addr[7:4] != 4'hF && (rd_en || wr_en)));

    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_bank0_hole_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr[7] && int'(addr[6:0]) >= BANK0_SIZE && (stk_acc || !bank_en))
        |=> rdata == 8'hFF);

    assert_ctrl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[7] && addr[7:4] != 4'hF) |=> rdata == 8'h00);

    assert_reset_out_R11: assert property (@(posedge clk)
        $rose(rst_n) |-> (rdata == 8'h00));
endmodule

bind bank_addr_map bank_addr_map_chk #(.BANK0_SIZE(BANK0_SIZE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .stk_acc (stk_acc),
    .bank_en (bank_en),
    .rdata   (rdata),
    .reg_sel (reg_sel),
    .ctrl_sel(ctrl_sel)
);

// File: tb/bank_addr_map_bench.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a behavioural model built from the requirements.
module bank_addr_map_bench;
    localparam int NB = 4;
    localparam int B0 = 112;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        stk_acc = 1'b0;
    logic        bank_en = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] reg_sel;
    logic        ctrl_sel;

    logic [7:0] m_ram [NB][128];
    logic [7:0] m_reg [16];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bank_addr_map #(.NUM_BANKS(NB), .BANK0_SIZE(B0)) u_bank_addr_map (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .stk_acc(stk_acc), .bank_en(bank_en), .rdata(rdata),
        .reg_sel(reg_sel), .ctrl_sel(ctrl_sel)
    );

    function automatic int eff_bank(input logic stk, input logic en);
        return (en && !stk) ? int'(m_reg[15]) : 0;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic stk, input logic en);
        int b;
        if (!a[7]) begin
            b = eff_bank(stk, en);
            if (b == 0) return (int'(a[6:0]) < B0) ? m_ram[0][a[6:0]] : 8'hFF;
            if (b < NB) return m_ram[b][a[6:0]];
            return 8'hFF;
        end
        if (a[7:4] == 4'hF) return m_reg[a[3:0]];
        return 8'h00;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [7:0] d,
                                        input logic stk, input logic en);
        int b;
        if (!a[7]) begin
            b = eff_bank(stk, en);
            if (b == 0 && int'(a[6:0]) < B0) m_ram[0][a[6:0]] = d;
            else if (b != 0 && b < NB)       m_ram[b][a[6:0]] = d;
        end else if (a[7:4] == 4'hF) begin
            m_reg[a[3:0]] = d;
        end
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_sel(input logic [7:0] a);
        logic [15:0] e_reg;
        e_reg = (a[7:4] == 4'hF) ? (16'd1 << a[3:0]) : 16'd0;
        check("R1 reg_sel", reg_sel, e_reg);
        check("R1 ctrl_sel", {15'd0, ctrl_sel}, {15'd0, a[7] && a[7:4] != 4'hF});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d,
                            input logic stk, input logic en);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0; stk_acc = stk; bank_en = en;
        #1 check_sel(a);
        model_write(a, d, stk, en);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic stk, input logic en,
                           input string tag);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0; stk_acc = stk; bank_en = en;
        e = exp_read(a, stk, en);
        #1 check_sel(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {8'd0, rdata}, {8'd0, e});
    endtask

    task automatic set_bank(input logic [7:0] b);
        do_write(8'hFF, b, 1'b0, 1'b1);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [7:0] hold_v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R11 rdata after reset", {8'd0, rdata}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 rdata out of reset", {8'd0, rdata}, 16'h0000);
        do_read(8'hF5, 1'b0, 1'b1, "R11 working reg zero");
        do_read(8'hFF, 1'b0, 1'b1, "R11 bank select zero");

        // Fill every implemented byte with a known pattern.
        set_bank(8'd0);
        for (int o = 0; o < B0; o++) do_write(8'(o), 8'(o * 3 + 1), 1'b0, 1'b1);
        for (int b = 1; b < NB; b++) begin
            set_bank(8'(b));
            for (int o = 0; o < 128; o++) do_write(8'(o), 8'(o ^ (b * 37)), 1'b0, 1'b1);
        end

        do_read(8'h7F, 1'b0, 1'b1, "R7 last offset of bank 3");
        set_bank(8'd1);
        do_read(8'h10, 1'b0, 1'b1, "R3 bank 1 routing");
        set_bank(8'd2);
        do_read(8'h10, 1'b0, 1'b1, "R3 bank 2 routing");

        set_bank(8'd1);
        do_write(8'hF3, 8'hA5, 1'b0, 1'b1);
        set_bank(8'd2);
        do_read(8'hF3, 1'b0, 1'b1, "R4 working reg across banks");
        do_read(8'hF3, 1'b0, 1'b0, "R4 working reg unbanked");

        do_read(8'h10, 1'b0, 1'b0, "R5 banking off uses bank 0");
        do_read(8'h10, 1'b1, 1'b1, "R6 stack access uses bank 0");
        do_read(8'h75, 1'b1, 1'b1, "R8 stack read in bank-0 hole");

        set_bank(8'd0);
        do_read(8'h70, 1'b0, 1'b1, "R8 bank-0 hole");
        do_write(8'h72, 8'h5A, 1'b0, 1'b1);
        do_read(8'h72, 1'b0, 1'b1, "R9 bank-0 hole write ignored");
        set_bank(8'd5);
        do_read(8'h10, 1'b0, 1'b1, "R8 bank beyond count");
        do_write(8'h20, 8'h3C, 1'b0, 1'b1);
        do_read(8'h20, 1'b0, 1'b1, "R9 missing bank write ignored");
        for (int b = 0; b < NB; b++) begin
            set_bank(8'(b));
            do_read(8'h20, 1'b0, 1'b1, "R9 other banks unchanged");
        end

        do_read(8'h85, 1'b0, 1'b1, "R10 control region read");
        do_read(8'hEF, 1'b0, 1'b1, "R10 control region top");

        do_read(8'h33, 1'b0, 1'b1, "R2 read latency");
        hold_v = rdata;
        repeat (3) @(negedge clk);
        check("R2 rdata holds", {8'd0, rdata}, {8'd0, hold_v});

        // Constrained random traffic.
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            logic [2:0] pick;
            logic       stk;
            logic       en;
            a    = 8'($urandom);
            pick = 3'($urandom);
            stk  = ($urandom % 5) == 0;
            en   = ($urandom % 6) != 0;
            if (pick == 3'd0)      set_bank(8'($urandom % (NB + 2)));
            else if (pick[0])      do_write(a, 8'($urandom), stk, en);
            else                   do_read(a, stk, en, "R3 random access");
        end

        finish_up();
    end
endmodule